// File: doc/BRIEF.md
# Maskable Interrupt Mode Sequencer

This block decides whether an active-low maskable interrupt request is taken. When it is, the block runs the response the processor core must follow. The core reports the last machine cycle of each instruction and the current T-state as a 2-bit code. The request is examined only at the clock edge that closes the state just before T3 or T1 of that last cycle. It is accepted only if the request pin is low at that edge, the global enable and the per-source enable are both set, and no non-maskable interrupt is pending.

Software picks one of three response modes with a mode-set strobe. In opcode mode the block runs an acknowledge cycle and captures a byte from the data bus at T3. The core executes that byte as the next instruction and does not stack the program counter. In fixed mode the block asks for a program-counter push and a restart at a constant address. In table mode the block runs an acknowledge cycle and captures the low byte of a vector-table pointer. It joins that byte with a high-byte register value and asks for a push followed by two table reads. On acceptance the block also pulses a clear of the global enable, so nested requests stay masked until software sets the flag again.

Top module: `irq_mode_seq`

## Requirements
- R1: The request is evaluated only at a rising clock edge where `lastCycle`=1 and `tState` is 1 (T2, the state before T3) or 3 (the final state before the next T1). It is accepted there only if `irqN`=0. Any other `tState` value (0=T1, 2=T3), or `lastCycle`=0, gives no acceptance.
- R2: No acceptance occurs while `gieIn`=0 or `srcEnIn`=0.
- R3: No acceptance occurs while `nmiPend`=1.
- R4: An acceptance raises `acceptP` and `gieClear` together for exactly one cycle, starting in the cycle after the sampling edge.
- R5: A `modeSetStb` with `modeCode` 0, 1 or 2 selects opcode, fixed or table mode. Code 3 leaves the mode unchanged. Reset selects opcode mode (0).
- R6: In opcode mode, `ackO` is high from the cycle after acceptance until the edge where `tState`=2 (T3). At that edge `dataIn` is captured. In the next cycle `respValid` is high for one cycle with `respAddr`={8'h00, captured byte}, `stackPc`=0 and `tableFetch`=0.
- R7: In fixed mode, `ackO` stays low. `respValid` is high for one cycle in the cycle after the sampling edge, with `respAddr`=16'h0038, `stackPc`=1 and `tableFetch`=0.
- R8: In table mode, the acknowledge and capture timing matches R6, and `vecHi` is also captured at the T3 edge. The response has `respAddr`={vecHi, byte[7:1], 0}, `stackPc`=1 and `tableFetch`=1.
- R9: The mode is latched at acceptance, so a mode-set strobe during a running sequence affects only later requests. No new acceptance occurs until the sequence has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| irqN | input | 1 | Active-low maskable request |
| nmiPend | input | 1 | Non-maskable interrupt pending, blocks acceptance |
| gieIn | input | 1 | Global interrupt enable flag |
| srcEnIn | input | 1 | Per-source enable bit |
| lastCycle | input | 1 | Core is in the last machine cycle |
| tState | input | 2 | T-state code: 0=T1, 1=T2, 2=T3, 3=final state |
| modeSetStb | input | 1 | Mode-set strobe |
| modeCode | input | 2 | Mode code for the strobe |
| dataIn | input | 8 | Data bus byte |
| vecHi | input | 8 | Vector-table high byte |
| acceptP | output | 1 | One-cycle acceptance pulse |
| gieClear | output | 1 | Pulse that clears the global enable |
| ackO | output | 1 | Acknowledge cycle in progress |
| respValid | output | 1 | Response fields valid (one cycle) |
| respAddr | output | 16 | Opcode, restart address or table address |
| stackPc | output | 1 | Core must push the program counter |
| tableFetch | output | 1 | Core must read two table bytes at `respAddr` |

## Verification
The assertions assume that the core drives `tState` as a legal code. They also assume that, during an acknowledge cycle, a T3 code eventually arrives. The stimulus always ends each acknowledge wait with a T3 cycle after zero to two filler cycles. During those filler cycles it holds the request low with the enables set and a sampling code present, so that any early re-acceptance would show. Mode-set strobes are applied only outside sampling edges, and the bench keeps its own copy of the expected current mode.

// File: rtl/irq_mode_pkg.sv
package irq_mode_pkg;
  typedef enum logic [1:0] {
    MODE_OP  = 2'd0,
    MODE_FIX = 2'd1,
    MODE_TBL = 2'd2
  } irqMode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_RESP = 2'd2
  } seqState_e;

  localparam logic [1:0] TS_T1    = 2'd0;
  localparam logic [1:0] TS_T2    = 2'd1;
  localparam logic [1:0] TS_T3    = 2'd2;
  localparam logic [1:0] TS_FINAL = 2'd3;

  typedef struct packed {
    logic     capture;
    logic     respond;
    irqMode_e mode;
  } ctrlStb_t;
endpackage

// File: rtl/irq_mode_ctrl.sv
module irq_mode_ctrl
  import irq_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       irqN,
  input  logic       nmiPend,
  input  logic       gieIn,
  input  logic       srcEnIn,
  input  logic       lastCycle,
  input  logic [1:0] tState,
  input  logic       modeSetStb,
  input  logic [1:0] modeCode,
  output logic       acceptP,
  output logic       ackO,
  output ctrlStb_t   stb
);
  seqState_e state;
  irqMode_e  curMode;
  irqMode_e  actMode;
  logic      sampleEdge;
  logic      acceptNow;

  assign sampleEdge = lastCycle && (tState == TS_T2 || tState == TS_FINAL);
  assign acceptNow  = (state == ST_IDLE) && sampleEdge && !irqN &&
                      gieIn && srcEnIn && !nmiPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curMode <= MODE_OP;
    end else if (modeSetStb && modeCode != 2'd3) begin
      curMode <= irqMode_e'(modeCode);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      actMode <= MODE_OP;
      acceptP <= 1'b0;
    end else begin
      acceptP <= acceptNow;
      unique case (state)
        ST_IDLE: if (acceptNow) begin
          actMode <= curMode;
          state   <= (curMode == MODE_FIX) ? ST_RESP : ST_ACK;
        end
        ST_ACK:  if (tState == TS_T3) state <= ST_RESP;
        ST_RESP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ackO        = (state == ST_ACK);
  assign stb.capture = (state == ST_ACK) && (tState == TS_T3);
  assign stb.respond = (state == ST_RESP);
  assign stb.mode    = actMode;

  // R4
  accept_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    acceptP |=> !acceptP);

  // R2
  accept_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    acceptP |-> $past(gieIn && srcEnIn && !nmiPend && !irqN));

  // R5
  mode_code3_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSetStb && modeCode == 2'd3) |=> $stable(curMode));

  // R7
  no_ack_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackO |-> (actMode != MODE_FIX));

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> !acceptP);
endmodule

// File: rtl/irq_mode_dp.sv
module irq_mode_dp
  import irq_mode_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] FIX_ADDR = 16'h0038
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [HI_W-1:0]   vecHi,
  output logic [ADDR_W-1:0] respAddr,
  output logic              stackPc,
  output logic              tableFetch
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] byteQ;
  logic [HI_W-1:0]   hiQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteQ <= '0;
      hiQ   <= '0;
    end else if (stb.capture) begin
      byteQ <= dataIn;
      hiQ   <= vecHi;
    end
  end

  always_comb begin
    unique case (stb.mode)
      MODE_FIX: respAddr = FIX_ADDR;
      MODE_TBL: respAddr = {hiQ, byteQ[DATA_W-1:1], 1'b0};
      default:  respAddr = ADDR_W'(byteQ);
    endcase
  end

  assign stackPc    = stb.respond && (stb.mode != MODE_OP);
  assign tableFetch = stb.respond && (stb.mode == MODE_TBL);

  // R6
  op_no_stack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.respond && stb.mode == MODE_OP) |-> !stackPc);

  // R8
  tbl_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    tableFetch |-> (respAddr[0] == 1'b0 && stackPc));
endmodule

// File: rtl/irq_mode_seq.sv
module irq_mode_seq
  import irq_mode_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] FIX_ADDR = 16'h0038
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqN,
  input  logic              nmiPend,
  input  logic              gieIn,
  input  logic              srcEnIn,
  input  logic              lastCycle,
  input  logic [1:0]        tState,
  input  logic              modeSetStb,
  input  logic [1:0]        modeCode,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [ADDR_W-DATA_W-1:0] vecHi,
  output logic              acceptP,
  output logic              gieClear,
  output logic              ackO,
  output logic              respValid,
  output logic [ADDR_W-1:0] respAddr,
  output logic              stackPc,
  output logic              tableFetch
);
  ctrlStb_t stb;

  irq_mode_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .irqN(irqN), .nmiPend(nmiPend),
    .gieIn(gieIn), .srcEnIn(srcEnIn), .lastCycle(lastCycle),
    .tState(tState), .modeSetStb(modeSetStb), .modeCode(modeCode),
    .acceptP(acceptP), .ackO(ackO), .stb(stb)
  );

  irq_mode_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIX_ADDR(FIX_ADDR)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .dataIn(dataIn), .vecHi(vecHi),
    .respAddr(respAddr), .stackPc(stackPc), .tableFetch(tableFetch)
  );

  assign gieClear  = acceptP;
  assign respValid = stb.respond;

  // R7
  resp_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);
endmodule

// File: tb/irq_mode_seq_tb.sv
module irq_mode_seq_tb_top;
  logic clk = 1'b0;
  logic rstN;
  logic irqN, nmiPend, gieIn, srcEnIn, lastCycle, modeSetStb;
  logic [1:0] tState, modeCode;
  logic [7:0] dataIn, vecHi;
  logic acceptP, gieClear, ackO, respValid, stackPc, tableFetch;
  logic [15:0] respAddr;

  int nChecks = 0;
  int nFails  = 0;
  int expMode = 0;

  always #5 clk = ~clk;

  irq_mode_seq dut_i (
    .clk(clk), .rstN(rstN), .irqN(irqN), .nmiPend(nmiPend), .gieIn(gieIn),
    .srcEnIn(srcEnIn), .lastCycle(lastCycle), .tState(tState),
    .modeSetStb(modeSetStb), .modeCode(modeCode), .dataIn(dataIn),
    .vecHi(vecHi), .acceptP(acceptP), .gieClear(gieClear), .ackO(ackO),
    .respValid(respValid), .respAddr(respAddr), .stackPc(stackPc),
    .tableFetch(tableFetch)
  );

  function automatic logic [15:0] expAddr(int m, logic [7:0] b, logic [7:0] h);
    if (m == 1) return 16'h0038;
    if (m == 2) return {h, b[7:1], 1'b0};
    return {8'h00, b};
  endfunction

  function automatic logic expAccept(logic pin, logic g, logic e, logic n,
                                     logic lc, logic [1:0] ts);
    return lc && (ts == 2'd1 || ts == 2'd3) && !pin && g && e && !n;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idleIn();
    irqN = 1'b1; lastCycle = 1'b0; tState = 2'd0; modeSetStb = 1'b0;
  endtask

  task automatic setMode(logic [1:0] c);
    modeSetStb = 1'b1; modeCode = c;
    @(negedge clk);
    modeSetStb = 1'b0;
    if (c != 2'd3) expMode = c;
  endtask

  task automatic trial(logic pin, logic g, logic e, logic n, logic lc,
                       logic [1:0] ts, logic [7:0] b, logic [7:0] h,
                       int waits, logic midSet, logic [1:0] midCode);
    logic acc;
    int   m;
    irqN = pin; gieIn = g; srcEnIn = e; nmiPend = n; lastCycle = lc; tState = ts;
    acc = expAccept(pin, g, e, n, lc, ts);
    m = expMode;
    @(negedge clk);
    // R1 R2 R3 R4: acceptance decision one cycle after the sampling edge
    chk("R1/R2/R3 acceptP", 32'(acceptP), 32'(acc));
    chk("R4 gieClear", 32'(gieClear), 32'(acc));
    if (acc && m == 1) begin
      // R7 fixed restart response
      chk("R7 respValid", 32'(respValid), 1);
      chk("R7 ackO", 32'(ackO), 0);
      chk("R7 respAddr", 32'(respAddr), 32'h0038);
      chk("R7 stackPc", 32'(stackPc), 1);
      chk("R7 tableFetch", 32'(tableFetch), 0);
      idleIn();
      @(negedge clk);
      chk("R4 acceptP falls", 32'(acceptP), 0);
      chk("R7 respValid single", 32'(respValid), 0);
    end else if (acc) begin
      chk("R6 ackO", 32'(ackO), 1);
      chk("R6 respValid early", 32'(respValid), 0);
      for (int w = 0; w < waits; w++) begin
        irqN = 1'b0; gieIn = 1'b1; srcEnIn = 1'b1; nmiPend = 1'b0;
        lastCycle = 1'b1; tState = 2'd1;
        if (midSet && w == 0) begin
          modeSetStb = 1'b1; modeCode = midCode;
          if (midCode != 2'd3) expMode = midCode;
        end
        @(negedge clk);
        modeSetStb = 1'b0;
        // R9 no re-acceptance while the sequence runs
        chk("R9 acceptP busy", 32'(acceptP), 0);
        chk("R6 ackO held", 32'(ackO), 1);
      end
      irqN = 1'b1; lastCycle = 1'b0; tState = 2'd2; dataIn = b; vecHi = h;
      @(negedge clk);
      dataIn = ~b; vecHi = ~h; tState = 2'd0;
      // R6 R8 R9 response uses the mode latched at acceptance
      chk("R6/R8 respValid", 32'(respValid), 1);
      chk("R6/R8 ackO done", 32'(ackO), 0);
      chk("R6/R8/R9 respAddr", 32'(respAddr), 32'(expAddr(m, b, h)));
      chk("R6/R8 stackPc", 32'(stackPc), 32'(m != 0));
      chk("R8 tableFetch", 32'(tableFetch), 32'(m == 2));
      idleIn();
      @(negedge clk);
      chk("R6 respValid single", 32'(respValid), 0);
    end else begin
      idleIn();
      @(negedge clk);
      chk("R1 no sequence", 32'(ackO | respValid), 0);
    end
  endtask

  initial begin
    #2000000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1f2e3d4c;
    void'($urandom(seed));
    rstN = 1'b0; gieIn = 1'b0; srcEnIn = 1'b0; nmiPend = 1'b0;
    modeCode = 2'd0; dataIn = 8'h00; vecHi = 8'h00;
    idleIn();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R4 reset acceptP", 32'(acceptP), 0);
    chk("R6 reset ackO", 32'(ackO), 0);
    chk("R7 reset respValid", 32'(respValid), 0);
    // R5 reset mode is opcode mode
    trial(0, 1, 1, 0, 1, 2'd1, 8'hC7, 8'h12, 1, 0, 0);
    // R1 final-state sampling code
    setMode(2'd1);
    trial(0, 1, 1, 0, 1, 2'd3, 8'h00, 8'h00, 0, 0, 0);
    // R5 code 3 ignored, table mode kept
    setMode(2'd2);
    setMode(2'd3);
    trial(0, 1, 1, 0, 1, 2'd1, 8'hFF, 8'hA5, 2, 0, 0);
    // R9 mode change mid-sequence affects only the next request
    trial(0, 1, 1, 0, 1, 2'd3, 8'h41, 8'h80, 1, 1, 2'd1);
    trial(0, 1, 1, 0, 1, 2'd1, 8'h00, 8'h00, 0, 0, 0);
    // R1 R2 R3 masked and off-window cases
    trial(0, 1, 1, 0, 1, 2'd0, 8'h00, 8'h00, 0, 0, 0);
    trial(0, 1, 1, 0, 1, 2'd2, 8'h00, 8'h00, 0, 0, 0);
    trial(0, 1, 1, 0, 0, 2'd1, 8'h00, 8'h00, 0, 0, 0);
    trial(0, 0, 1, 0, 1, 2'd1, 8'h00, 8'h00, 0, 0, 0);
    trial(0, 1, 0, 0, 1, 2'd1, 8'h00, 8'h00, 0, 0, 0);
    trial(0, 1, 1, 1, 1, 2'd1, 8'h00, 8'h00, 0, 0, 0);
    trial(1, 1, 1, 0, 1, 2'd1, 8'h00, 8'h00, 0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 3 == 0) setMode(2'($urandom));
      trial(($urandom % 4) == 0, ($urandom % 6) != 0, ($urandom % 6) != 0,
            ($urandom % 8) == 0, ($urandom % 5) != 0, 2'($urandom),
            8'($urandom), 8'($urandom), int'($urandom % 3),
            ($urandom % 4) == 0, 2'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule